// File: doc/BRIEF.md
# Dual-Channel Sign-Magnitude Converter Register Front End

This block is the digital side of a two-channel converter that sits on an 8-bit processor bus. A write strobe, qualified by an active-low chip select, stores one byte into the channel that a single address line picks. Within that byte, the upper bit becomes a direction level and the lower seven bits become a magnitude code. The two magnitude codes drive resistor-ladder converters. The two direction levels go straight to the phase input of a motor driver, so that a processor can set winding current level and polarity for microstepping.

The bus is sampled on the block clock. An optional input register stage can be selected by a parameter. A write takes effect on the first sampled rising edge of the strobe. Two reset sources clear every register and so drive all outputs to zero: a power-on request and an active-high external clear. Both act asynchronously and are released in step with the clock.

Top module: `smdac_front`

## Requirements
- R1: A channel register loads only on a rising edge of `bus_wr`. While the strobe stays high, changes on the data or address lines have no effect until the strobe falls and rises again.
- R2: With `bus_cs_n` low and `bus_sel` = 0, a write places data bit 7 on `sign_bus[0]` and data bits 6..0 on `mag_bus[6:0]`.
- R3: With `bus_cs_n` low and `bus_sel` = 1, a write places data bit 7 on `sign_bus[1]` and data bits 6..0 on `mag_bus[13:7]`.
- R4: A strobe edge with `bus_cs_n` high changes no output, whatever `bus_sel` holds.
- R5: The direction level equals data bit 7 without inversion: 1 gives a high sign output and 0 gives a low one.
- R6: A write to one channel leaves the magnitude and sign of the other channel unchanged.
- R7: Raising `ext_clr` drives every magnitude and sign output to zero at once, without waiting for a clock edge.
- R8: While `por` is held high from start-up, all outputs read zero.
- R9: Reset wins over writes. A strobe edge while any reset is active is lost. A strobe that is still high when reset releases does not count as a rising edge.
- R10: Every one of the 128 magnitude codes can be written and read back. The ideal level, code × Vref / 128, rises strictly with the code and tops out at Vref minus one LSB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock on which the bus is sampled |
| por | input | 1 | Power-on clear request, active high, asynchronous |
| ext_clr | input | 1 | External clear, active high, asynchronous |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_sel | input | 1 | Channel select: 0 picks channel 1, 1 picks channel 2 |
| bus_wr | input | 1 | Write strobe, captured on its rising edge |
| bus_data | input | 8 | Bit 7 is the direction, bits 6..0 the magnitude |
| mag_bus | output | 14 | Channel 1 magnitude in bits 6..0, channel 2 magnitude in bits 13..7 |
| sign_bus | output | 2 | Bit 0 is the channel 1 direction, bit 1 the channel 2 direction |

## Verification
A clear and a bus write can land in the same cycle, and that collision is the part that deserves the most care. The bench raises `ext_clr` between clock edges after a channel holds a nonzero code. It then issues a full write while the clear is held, and separately leaves the strobe high across the release of the clear. Every output must read zero after each step: immediately after the clear rises, after the blocked write, and several cycles after release. A nonzero output in any of these windows is a failure.

// File: rtl/smdac_pkg.sv
package smdac_pkg;

   // Input capture variant of the bus decoder
   typedef enum logic {
      IN_DIRECT  = 1'b0,
      IN_FLOPPED = 1'b1
   } in_mode_e;

   localparam int unsigned DEF_DATA_W = 8;
   localparam int unsigned DEF_NUM_CH = 2;

   // Width of the channel address for a given channel count
   function automatic int unsigned sel_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/smdac_rst.sv
module smdac_rst #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic arst,
   output logic rst_q
);

   if (STAGES < 1) begin : g_bad_stages
      $error("smdac_rst: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain;

   // Assert at once, release after STAGES clean edges
   always_ff @(posedge clk or posedge arst) begin
      if (arst) chain <= '1;
      else      chain <= chain << 1;
   end

   assign rst_q = chain[STAGES-1];

endmodule

// File: rtl/smdac_bus_dec.sv
module smdac_bus_dec
   import smdac_pkg::*;
#(
   parameter int unsigned DATA_W  = DEF_DATA_W,
   parameter int unsigned NUM_CH  = DEF_NUM_CH,
   parameter in_mode_e    IN_MODE = IN_FLOPPED,
   localparam int unsigned SEL_W  = sel_width(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cs_n,
   input  logic [SEL_W-1:0]  sel,
   input  logic              wr,
   input  logic [DATA_W-1:0] data,
   output logic [NUM_CH-1:0] we,
   output logic [DATA_W-1:0] wdata
);

   logic              cs_s;
   logic [SEL_W-1:0]  sel_s;
   logic              wr_s;
   logic [DATA_W-1:0] data_s;
   logic              wr_prev;
   logic              fire;

   if (IN_MODE == IN_FLOPPED) begin : g_in_reg
      always_ff @(posedge clk or posedge rst) begin
         if (rst) begin
            cs_s   <= 1'b1;
            sel_s  <= '0;
            wr_s   <= 1'b1;
            data_s <= '0;
         end else begin
            cs_s   <= cs_n;
            sel_s  <= sel;
            wr_s   <= wr;
            data_s <= data;
         end
      end
   end else begin : g_in_direct
      assign cs_s   = cs_n;
      assign sel_s  = sel;
      assign wr_s   = wr;
      assign data_s = data;
   end

   // Previous strobe level; reset high so a strobe held across
   // the release of reset is not taken as a fresh edge.
   always_ff @(posedge clk or posedge rst) begin
      if (rst) wr_prev <= 1'b1;
      else     wr_prev <= wr_s;
   end

   assign fire  = wr_s & ~wr_prev & ~cs_s & ~rst;
   assign wdata = data_s;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_we
      assign we[g] = fire && (sel_s == SEL_W'(g));
   end

   AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (rst)
      $onehot0(we)) else $error("two channels enabled at once"); // R6

   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
      (|we) |=> !(|we)) else $error("write enable lasted two cycles"); // R1

endmodule

// File: rtl/smdac_chan.sv
module smdac_chan #(
   parameter int unsigned MAG_W = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             we,
   input  logic [MAG_W:0]   wdata,
   output logic [MAG_W-1:0] mag,
   output logic             sign
);

   if (MAG_W < 1) begin : g_bad_mag
      $error("smdac_chan: MAG_W must be at least 1");
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         mag  <= '0;
         sign <= 1'b0;
      end else if (we) begin
         mag  <= wdata[MAG_W-1:0];
         sign <= wdata[MAG_W];
      end
   end

   AST_LOAD_ON_WE: assert property (@(posedge clk) disable iff (rst)
      we |=> (mag == $past(wdata[MAG_W-1:0]) && sign == $past(wdata[MAG_W])))
      else $error("channel did not load written byte"); // R2 R3 R5

   AST_HOLD_NO_WE: assert property (@(posedge clk) disable iff (rst)
      !we |=> $stable({sign, mag}))
      else $error("channel changed without a write"); // R4 R6

endmodule

// File: rtl/smdac_front.sv
module smdac_front
   import smdac_pkg::*;
#(
   parameter int unsigned DATA_W    = DEF_DATA_W,
   parameter int unsigned NUM_CH    = DEF_NUM_CH,
   parameter int unsigned RST_SYNC  = 2,
   parameter in_mode_e    IN_MODE   = IN_FLOPPED
) (
   input  logic                           clk,
   input  logic                           por,
   input  logic                           ext_clr,
   input  logic                           bus_cs_n,
   input  logic [sel_width(NUM_CH)-1:0]   bus_sel,
   input  logic                           bus_wr,
   input  logic [DATA_W-1:0]              bus_data,
   output logic [NUM_CH*(DATA_W-1)-1:0]   mag_bus,
   output logic [NUM_CH-1:0]              sign_bus
);

   localparam int unsigned MAG_W = DATA_W - 1;
   localparam int unsigned SEL_W = sel_width(NUM_CH);

   if (DATA_W < 2) begin : g_bad_data
      $error("smdac_front: DATA_W must be at least 2");
   end
   if (NUM_CH < 2 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_ch
      $error("smdac_front: NUM_CH must be a power of two, at least 2");
   end

   logic              arst;
   logic              rst_int;
   logic [NUM_CH-1:0] we;
   logic [DATA_W-1:0] wdata;

   assign arst = por | ext_clr;

   smdac_rst #(
      .STAGES (RST_SYNC)
   ) u_rst (
      .clk   (clk),
      .arst  (arst),
      .rst_q (rst_int)
   );

   smdac_bus_dec #(
      .DATA_W  (DATA_W),
      .NUM_CH  (NUM_CH),
      .IN_MODE (IN_MODE)
   ) u_dec (
      .clk   (clk),
      .rst   (rst_int),
      .cs_n  (bus_cs_n),
      .sel   (bus_sel),
      .wr    (bus_wr),
      .data  (bus_data),
      .we    (we),
      .wdata (wdata)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [MAG_W-1:0] mag_c;
      logic             sign_c;

      smdac_chan #(
         .MAG_W (MAG_W)
      ) u_chan (
         .clk   (clk),
         .rst   (rst_int),
         .we    (we[c]),
         .wdata (wdata),
         .mag   (mag_c),
         .sign  (sign_c)
      );

      assign mag_bus[c*MAG_W +: MAG_W] = mag_c;
      assign sign_bus[c]               = sign_c;
   end

   always @(negedge clk) begin
      if (rst_int) begin
         AST_RESET_ZERO: assert (mag_bus == '0 && sign_bus == '0)
            else $error("outputs not cleared during reset"); // R7 R8 R9
      end
   end

endmodule

// File: tb/tb_smdac_front.sv
module tb_smdac_front;

   localparam int MAG_W = 7;
   localparam real VREF = 2.5;

   logic        clk = 1'b0;
   logic        por;
   logic        ext_clr;
   logic        bus_cs_n;
   logic [0:0]  bus_sel;
   logic        bus_wr;
   logic [7:0]  bus_data;
   logic [13:0] mag_bus;
   logic [1:0]  sign_bus;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk; // 50 MHz

   smdac_front dut (
      .clk      (clk),
      .por      (por),
      .ext_clr  (ext_clr),
      .bus_cs_n (bus_cs_n),
      .bus_sel  (bus_sel),
      .bus_wr   (bus_wr),
      .bus_data (bus_data),
      .mag_bus  (mag_bus),
      .sign_bus (sign_bus)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic bus_write(input logic cs_n, input logic sel, input logic [7:0] d);
      @(negedge clk);
      bus_cs_n = cs_n; bus_sel = sel; bus_data = d; bus_wr = 1'b0;
      @(negedge clk);
      bus_wr = 1'b1;
      repeat (2) @(negedge clk);
      bus_wr = 1'b0;
      repeat (3) @(negedge clk);
      bus_cs_n = 1'b1;
   endtask

   task automatic t_por_state;
      repeat (3) @(negedge clk);
      check("R8 mag during por", 32'(mag_bus), 0);
      check("R8 sign during por", 32'(sign_bus), 0);
      por = 1'b0;
      repeat (4) @(negedge clk);
      check("R8 mag after por", 32'(mag_bus), 0);
   endtask

   task automatic t_write_ch1;
      bus_write(1'b0, 1'b0, 8'hA5);
      check("R2 ch1 mag", 32'(mag_bus[6:0]), 32'h25);
      check("R5 ch1 sign high", 32'(sign_bus[0]), 1);
      check("R6 ch2 untouched", 32'({sign_bus[1], mag_bus[13:7]}), 0);
   endtask

   task automatic t_write_ch2;
      bus_write(1'b0, 1'b1, 8'h3C);
      check("R3 ch2 mag", 32'(mag_bus[13:7]), 32'h3C);
      check("R5 ch2 sign low", 32'(sign_bus[1]), 0);
      check("R6 ch1 kept", 32'({sign_bus[0], mag_bus[6:0]}), 32'hA5);
      bus_write(1'b0, 1'b1, 8'hFF);
      check("R3 ch2 full", 32'({sign_bus[1], mag_bus[13:7]}), 32'hFF);
      check("R6 ch1 kept again", 32'({sign_bus[0], mag_bus[6:0]}), 32'hA5);
   endtask

   task automatic t_cs_high;
      bus_write(1'b1, 1'b0, 8'h11);
      bus_write(1'b1, 1'b1, 8'h22);
      check("R4 ch1 unchanged", 32'({sign_bus[0], mag_bus[6:0]}), 32'hA5);
      check("R4 ch2 unchanged", 32'({sign_bus[1], mag_bus[13:7]}), 32'hFF);
   endtask

   task automatic t_strobe_held;
      @(negedge clk);
      bus_cs_n = 1'b0; bus_sel = 1'b0; bus_data = 8'h07; bus_wr = 1'b0;
      @(negedge clk);
      bus_wr = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 first edge loads", 32'({sign_bus[0], mag_bus[6:0]}), 32'h07);
      bus_data = 8'h99; bus_sel = 1'b1;
      repeat (4) @(negedge clk);
      check("R1 held strobe ch1", 32'({sign_bus[0], mag_bus[6:0]}), 32'h07);
      check("R1 held strobe ch2", 32'({sign_bus[1], mag_bus[13:7]}), 32'hFF);
      bus_wr = 1'b0;
      @(negedge clk);
      bus_wr = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 new edge loads", 32'({sign_bus[1], mag_bus[13:7]}), 32'h99);
      bus_wr = 1'b0; bus_cs_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_clear_collision;
      bus_write(1'b0, 1'b0, 8'hC3);
      @(negedge clk);
      #3 ext_clr = 1'b1;
      #1;
      check("R7 mag cleared at once", 32'(mag_bus), 0);
      check("R7 sign cleared at once", 32'(sign_bus), 0);
      bus_write(1'b0, 1'b1, 8'hE7);
      check("R9 write during clear lost", 32'({sign_bus, mag_bus}), 0);
      @(negedge clk);
      bus_cs_n = 1'b0; bus_sel = 1'b0; bus_data = 8'h5A; bus_wr = 1'b1;
      @(negedge clk);
      ext_clr = 1'b0;
      repeat (6) @(negedge clk);
      check("R9 held strobe across release", 32'({sign_bus, mag_bus}), 0);
      bus_wr = 1'b0; bus_cs_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_level_sweep;
      real prev_lvl;
      real lvl;
      real exp_lvl;
      int  bad_mono;
      int  bad_lvl;
      prev_lvl = -1.0;
      bad_mono = 0;
      bad_lvl  = 0;
      for (int code = 0; code < 128; code++) begin
         bus_write(1'b0, 1'b0, {code[0], code[6:0]});
         check("R10 code readback", 32'({sign_bus[0], mag_bus[6:0]}), 32'({code[0], code[6:0]}));
         lvl     = real'(mag_bus[6:0]) * VREF / 128.0;
         exp_lvl = real'(code) * VREF / 128.0;
         if (lvl < exp_lvl - 1.0e-9 || lvl > exp_lvl + 1.0e-9) bad_lvl++;
         if (!(lvl > prev_lvl)) bad_mono++;
         prev_lvl = lvl;
      end
      check("R10 level model", 32'(bad_lvl), 0);
      check("R10 monotonic", 32'(bad_mono), 0);
      n_chk++;
      if (prev_lvl < VREF - VREF / 128.0 - 1.0e-9 || prev_lvl > VREF - VREF / 128.0 + 1.0e-9) begin
         n_fail++;
         $display("FAIL R10 top level: got %f expected %f", prev_lvl, VREF - VREF / 128.0);
      end
   endtask

   initial begin
      por = 1'b1; ext_clr = 1'b0;
      bus_cs_n = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0; bus_data = 8'h00;
      t_por_state();
      t_write_ch1();
      t_write_ch2();
      t_cs_high();
      t_strobe_held();
      t_clear_collision();
      t_level_sweep();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule